// File: doc/BRIEF.md
# Interlaced Vertical Sync Generator

This block drives the vertical sync line of an interlaced video output with half-line resolution. It follows the data-enable and horizontal-sync inputs of the pixel stream and a half-line tick from a separate timer. It steps through the visible region one line at a time. Once it finds a line with data-enable low, it counts the front porch, holds vertical sync asserted for a programmed number of half-lines, and then counts the back porch.

The parity of a field is not programmed. The block works it out from the picture. After each back porch it samples data-enable. If data-enable is high, the timing has slipped, so the block returns to the first parameter set. If it is low, the block moves on to the next set, and after the last set it returns to the first. Each field therefore uses its own front-porch and back-porch lengths. These lengths come from one packed porch word.

Software builds that word from the front porch F (in half-lines) and the back porch B. F is first clamped to the range 3 to 256. Any excess above 256 is added to B. Any shortfall below 3 is taken from B, and B never drops below 1. The first set stores F-2 and B-1. The second set stores F-3 and B.

Top module: `ivs_vsync_gen`

## Requirements
- R1: During and after reset, `vsync_o` sits at its inactive level, which is equal to `vs_inv`, and the first parameter set is selected.
- R2: Each line of the visible region is handled in this order: wait for active HSYNC, wait HS_DELAY cycles, discard any pending tick, then wait for the next tick and sample DE. The front porch starts at the first such mid-line tick that finds DE inactive. The block gives exactly one VSYNC pulse per field.
- R3: VSYNC becomes active after exactly N+1 further ticks, where N is the front-porch byte of the current set. For set 0 that byte is `porch_word[7:0]`. For set 1 it is `porch_word[23:16]`.
- R4: VSYNC stays active for exactly `sync_len`+1 ticks.
- R5: After VSYNC ends, the block counts M+1 ticks and then samples DE. M is the back-porch byte: `porch_word[15:8]` for set 0 and `porch_word[31:24]` for set 1.
- R6: If DE is active at the sample after the back porch, the next field uses set 0.
- R7: If DE is inactive at that sample, set 0 is followed by set 1, and set 1 is followed by set 0.
- R8: A tick that arrives between the start of HSYNC and the discard point is not taken as the mid-line tick.
- R9: `de_inv`, `hs_inv` and `vs_inv` each invert only their own signal. Active DE is `de_pin ^ de_inv`, active HSYNC is `hsync_pin ^ hs_inv`, and `vsync_o` is the active VSYNC XOR `vs_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| de_pin | input | 1 | Data-enable from the pixel stream |
| hsync_pin | input | 1 | Horizontal sync from the pixel stream |
| halfline_tick | input | 1 | One-cycle pulse from the half-line timer |
| porch_word | input | 32 | Packed porch bytes for the two fields |
| sync_len | input | 8 | VSYNC width in half-lines minus 1 |
| de_inv | input | 1 | Invert DE |
| hs_inv | input | 1 | Invert HSYNC |
| vs_inv | input | 1 | Invert VSYNC |
| vsync_o | output | 1 | Vertical sync output |

## Verification
The bench measures every porch and sync interval by counting ticks, so an off-by-one in any countdown shows up as a wrong count. It places the end of each blanking interval on one side or the other of the post-porch DE sample. A miscounted back porch then samples DE on the wrong side and picks the wrong set for the next field. Without the stale-tick discard, the block would take the tick sent just after HSYNC as the mid-line tick. It would then start the front porch one half-line early, and the bench would see that. Further cases cover the largest front porch (byte 254), zero-length porch and sync bytes, and every polarity combination.

// File: rtl/ivs_pkg.sv
package ivs_pkg;

  typedef enum logic [3:0] {
    ST_REWIND,
    ST_WAIT_DE,
    ST_WAIT_HS,
    ST_SETTLE,
    ST_FLUSH,
    ST_MID,
    ST_FRONT,
    ST_SYNC,
    ST_BACK,
    ST_DECIDE
  } seq_state_e;

endpackage

// File: rtl/ivs_pin_cond.sv
module ivs_pin_cond #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  input  logic [N-1:0] inv,
  output logic [N-1:0] q
);

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic r;
    always_ff @(posedge clk) begin
      if (rst) r <= 1'b0;
      else     r <= pin[i] ^ inv[i];
    end
    assign q[i] = r;
  end

endmodule

// File: rtl/ivs_tick_latch.sv
module ivs_tick_latch (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic take,
  input  logic flush,
  output logic pend
);

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else     pend <= tick | (pend & ~take & ~flush);
  end

endmodule

// File: rtl/ivs_field_sel.sv
module ivs_field_sel #(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SETS  = 2,
  localparam int unsigned WORD_W = SETS * 2 * CNT_W,
  localparam int unsigned SEL_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word,
  input  logic              rewind,
  input  logic              advance,
  output logic [SEL_W-1:0]  sel,
  output logic              last_set,
  output logic [CNT_W-1:0]  front_len,
  output logic [CNT_W-1:0]  back_len
);

  logic [WORD_W-1:0] shadow;
  logic [CNT_W-1:0]  front_arr [SETS];
  logic [CNT_W-1:0]  back_arr  [SETS];

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      sel    <= '0;
    end else if (rewind) begin
      shadow <= word;
      sel    <= '0;
    end else if (advance) begin
      sel <= sel + SEL_W'(1);
    end
  end

  for (genvar k = 0; k < SETS; k++) begin : g_set
    assign front_arr[k] = shadow[(2*k)*CNT_W   +: CNT_W];
    assign back_arr[k]  = shadow[(2*k+1)*CNT_W +: CNT_W];
  end

  assign front_len = front_arr[sel];
  assign back_len  = back_arr[sel];
  assign last_set  = (sel == SEL_W'(SETS - 1));

endmodule

// File: rtl/ivs_sequencer.sv
module ivs_sequencer
  import ivs_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SYNC_W   = 8,
  parameter int unsigned HS_DELAY = 7,
  localparam int unsigned CW = (CNT_W > SYNC_W) ? CNT_W : SYNC_W,
  localparam int unsigned DW = (HS_DELAY > 1) ? $clog2(HS_DELAY) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              de_a,
  input  logic              hs_a,
  input  logic              pend,
  input  logic [CNT_W-1:0]  front_len,
  input  logic [CNT_W-1:0]  back_len,
  input  logic [SYNC_W-1:0] sync_len,
  input  logic              last_set,
  output logic              take,
  output logic              flush,
  output logic              rewind,
  output logic              advance,
  output logic              vs_act,
  output seq_state_e        state
);

  seq_state_e    state_n;
  logic [CW-1:0] cnt, cnt_n;
  logic [DW-1:0] dly, dly_n;

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    dly_n   = dly;
    take    = 1'b0;
    flush   = 1'b0;
    rewind  = 1'b0;
    advance = 1'b0;
    case (state)
      ST_REWIND: begin
        rewind  = 1'b1;
        state_n = ST_WAIT_DE;
      end
      ST_WAIT_DE: if (de_a) state_n = ST_WAIT_HS;
      ST_WAIT_HS: if (hs_a) begin
        state_n = ST_SETTLE;
        dly_n   = DW'(HS_DELAY - 1);
      end
      ST_SETTLE: begin
        if (dly == '0) state_n = ST_FLUSH;
        else           dly_n   = dly - DW'(1);
      end
      ST_FLUSH: begin
        flush   = 1'b1;
        state_n = ST_MID;
      end
      ST_MID: if (pend) begin
        take = 1'b1;
        if (de_a) begin
          state_n = ST_WAIT_HS;
        end else begin
          state_n = ST_FRONT;
          cnt_n   = CW'(front_len);
        end
      end
      ST_FRONT: if (pend) begin
        take = 1'b1;
        if (cnt == '0) begin
          state_n = ST_SYNC;
          cnt_n   = CW'(sync_len);
        end else begin
          cnt_n = cnt - CW'(1);
        end
      end
      ST_SYNC: if (pend) begin
        take = 1'b1;
        if (cnt == '0) begin
          state_n = ST_BACK;
          cnt_n   = CW'(back_len);
        end else begin
          cnt_n = cnt - CW'(1);
        end
      end
      ST_BACK: if (pend) begin
        take = 1'b1;
        if (cnt == '0) state_n = ST_DECIDE;
        else           cnt_n   = cnt - CW'(1);
      end
      ST_DECIDE: begin
        if (de_a || last_set) begin
          state_n = ST_REWIND;
        end else begin
          advance = 1'b1;
          state_n = ST_WAIT_DE;
        end
      end
      default: state_n = ST_REWIND;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_REWIND;
      cnt    <= '0;
      dly    <= '0;
      vs_act <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      dly    <= dly_n;
      vs_act <= (state_n == ST_SYNC);
    end
  end

endmodule

// File: rtl/ivs_vsync_gen.sv
module ivs_vsync_gen
  import ivs_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SYNC_W   = 8,
  parameter int unsigned SETS     = 2,
  parameter int unsigned HS_DELAY = 7,
  localparam int unsigned WORD_W = SETS * 2 * CNT_W,
  localparam int unsigned SEL_W  = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              de_pin,
  input  logic              hsync_pin,
  input  logic              halfline_tick,
  input  logic [WORD_W-1:0] porch_word,
  input  logic [SYNC_W-1:0] sync_len,
  input  logic              de_inv,
  input  logic              hs_inv,
  input  logic              vs_inv,
  output logic              vsync_o
);

  logic [2:0]       cond_q;
  logic             de_a, hs_a, tick_a;
  logic             tick_pend, take, flush, rewind, advance;
  logic             vs_act, last_set;
  logic [SEL_W-1:0] set_sel;
  logic [CNT_W-1:0] front_len, back_len;
  seq_state_e       seq_state;

  ivs_pin_cond #(.N(3)) u_cond (
    .clk (clk),
    .rst (rst),
    .pin ({halfline_tick, hsync_pin, de_pin}),
    .inv ({1'b0, hs_inv, de_inv}),
    .q   (cond_q)
  );

  assign de_a   = cond_q[0];
  assign hs_a   = cond_q[1];
  assign tick_a = cond_q[2];

  ivs_tick_latch u_tick (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick_a),
    .take  (take),
    .flush (flush),
    .pend  (tick_pend)
  );

  ivs_field_sel #(.CNT_W(CNT_W), .SETS(SETS)) u_fsel (
    .clk       (clk),
    .rst       (rst),
    .word      (porch_word),
    .rewind    (rewind),
    .advance   (advance),
    .sel       (set_sel),
    .last_set  (last_set),
    .front_len (front_len),
    .back_len  (back_len)
  );

  ivs_sequencer #(.CNT_W(CNT_W), .SYNC_W(SYNC_W), .HS_DELAY(HS_DELAY)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .de_a      (de_a),
    .hs_a      (hs_a),
    .pend      (tick_pend),
    .front_len (front_len),
    .back_len  (back_len),
    .sync_len  (sync_len),
    .last_set  (last_set),
    .take      (take),
    .flush     (flush),
    .rewind    (rewind),
    .advance   (advance),
    .vs_act    (vs_act),
    .state     (seq_state)
  );

  always_ff @(posedge clk) begin
    if (rst) vsync_o <= vs_inv;
    else     vsync_o <= vs_act ^ vs_inv;
  end

endmodule

// File: rtl/ivs_vsync_chk.sv
module ivs_vsync_chk
  import ivs_pkg::*;
#(
  parameter int unsigned SEL_W = 1
) (
  input logic             clk,
  input logic             rst,
  input seq_state_e       state,
  input logic             pend,
  input logic             tick_a,
  input logic             de_a,
  input logic             vs_act,
  input logic             vsync_o,
  input logic             vs_inv,
  input logic [SEL_W-1:0] set_sel
);

  a_r1_idle_level: assert property (@(posedge clk) disable iff (rst)
    !vs_act |=> (vsync_o == $past(vs_inv)));

  a_r3_sync_starts_on_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(vs_act) |-> ($past(state) == ST_FRONT) && $past(pend));

  a_r4_sync_ends_on_tick: assert property (@(posedge clk) disable iff (rst)
    $fell(vs_act) |-> ($past(state) == ST_SYNC) && $past(pend));

  a_r8_stale_tick_dropped: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FLUSH && !tick_a) |=> !pend);

  a_r6_active_de_rewinds: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECIDE && de_a) |=> ##1 (set_sel == '0));

  a_r7_idle_de_advances: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DECIDE && !de_a && set_sel == '0) |=> (set_sel == SEL_W'(1)));

endmodule

bind ivs_vsync_gen ivs_vsync_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .state   (seq_state),
  .pend    (tick_pend),
  .tick_a  (tick_a),
  .de_a    (de_a),
  .vs_act  (vs_act),
  .vsync_o (vsync_o),
  .vs_inv  (vs_inv),
  .set_sel (set_sel)
);

// File: tb/tb_ivs_vsync_gen.sv
module tb_ivs_vsync_gen;

  localparam int LINE   = 40;
  localparam int HS_LEN = 4;
  localparam int TK_A   = 2;
  localparam int TK_B   = 22;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst = 1'b1;
  logic        de_pin = 1'b0, hs_pin = 1'b0, tick = 1'b0;
  logic        de_inv = 1'b0, hs_inv = 1'b0, vs_inv = 1'b0;
  logic [31:0] word = '0;
  logic [7:0]  slen = '0;
  logic        vsync_o;

  ivs_vsync_gen dut (
    .clk           (clk),
    .rst           (rst),
    .de_pin        (de_pin),
    .hsync_pin     (hs_pin),
    .halfline_tick (tick),
    .porch_word    (word),
    .sync_len      (slen),
    .de_inv        (de_inv),
    .hs_inv        (hs_inv),
    .vs_inv        (vs_inv),
    .vsync_o       (vsync_o)
  );

  int    checks = 0, fails = 0;
  bit    done = 0;
  int    ticks, t_m, t_rise, decide_at, phase, pulses, b_exp, p_exp;
  bit    armed, decide_pend, prev_vs, field_seen;
  string tag;

  task automatic chk(input string msg, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", msg, got, exp);
    end
  endtask

  function automatic int fp_of(input int ph);
    return (ph == 0) ? int'(word[7:0]) : int'(word[23:16]);
  endfunction

  function automatic int bp_of(input int ph);
    return (ph == 0) ? int'(word[15:8]) : int'(word[31:24]);
  endfunction

  function automatic logic [31:0] pack(input int vfp_i, input int vbp_i);
    int f = vfp_i;
    int b = vbp_i;
    if (f > 256) begin
      b = b + f - 256;
      f = 256;
    end else if (f < 3) begin
      b = (b > 3 - f) ? (b - 3 + f) : 1;
      f = 3;
    end
    return {8'(b), 8'(f - 3), 8'(b - 1), 8'(f - 2)};
  endfunction

  task automatic drive(input bit de_a, input bit hs_a, input bit tk);
    bit vs_now;
    @(negedge clk);
    vs_now = vsync_o ^ vs_inv;
    if (vs_now && !prev_vs) begin
      pulses++;
      if (!armed) chk("R2 pulse without end of active region", 1, 0);
      else chk({"R3 front porch, R9 polarity, ", tag}, ticks - t_m, b_exp + 1);
      t_rise = ticks;
    end
    if (!vs_now && prev_vs) begin
      chk("R4 sync width", ticks - t_rise, int'(slen) + 1);
      decide_at   = ticks + p_exp + 1;
      decide_pend = 1;
      armed       = 0;
    end
    prev_vs = vs_now;
    de_pin  = de_a ^ de_inv;
    hs_pin  = hs_a ^ hs_inv;
    tick    = tk;
    if (tk) begin
      ticks++;
      if (decide_pend && ticks == decide_at) begin
        decide_pend = 0;
        if (de_a) begin
          phase = 0; tag = "R5 R6 active DE";
        end else if (phase == 0) begin
          phase = 1; tag = "R5 R7 second set";
        end else begin
          phase = 0; tag = "R5 R7 rewind";
        end
      end
    end
  endtask

  task automatic line(input bit de_a, input bit mark);
    for (int c = 0; c < LINE; c++) begin
      drive(de_a, c < HS_LEN, (c == TK_A) || (c == TK_B));
      if (mark && c == TK_B) begin
        // R2 R8: this is the first mid-line tick with DE low
        if (field_seen) chk("R2 one pulse per field", pulses, 1);
        field_seen = 1;
        pulses = 0;
        t_m    = ticks;
        armed  = 1;
        b_exp  = fp_of(phase);
        p_exp  = bp_of(phase);
      end
    end
  endtask

  task automatic field(input int act);
    int d, bl;
    for (int l = 0; l < act; l++) line(1'b1, 1'b0);
    d  = fp_of(phase) + int'(slen) + bp_of(phase) + 3;
    bl = ($urandom_range(0, 1) == 0) ? (1 + d) / 2
                                     : (1 + d) / 2 + 1 + int'($urandom_range(0, 1));
    line(1'b0, 1'b1);
    for (int l = 1; l < bl; l++) line(1'b0, 1'b0);
  endtask

  task automatic segment(input logic [31:0] w, input logic [7:0] s,
                         input logic [2:0] inv, input int nf);
    rst = 1'b1;
    word = w; slen = s;
    {vs_inv, hs_inv, de_inv} = inv;
    ticks = 0; armed = 0; decide_pend = 0; phase = 0; pulses = 0;
    field_seen = 0; prev_vs = 0; tag = "R1 first set";
    for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, 1'b0);
    rst = 1'b0;
    drive(1'b0, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b0);
    chk("R1 reset level R9", int'(vsync_o), int'(vs_inv));
    prev_vs = 0;
    for (int f = 0; f < nf; f++) field(int'($urandom_range(3, 8)));
    line(1'b0, 1'b0);
    line(1'b0, 1'b0);
    chk("R2 one pulse in last field", pulses, 1);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    segment(pack(5, 6), 8'd2, 3'b000, 4);
    segment(pack(1, 4), 8'd0, 3'b111, 4);
    segment(pack(300, 2), 8'd5, 3'b010, 3);
    segment({8'd0, 8'd0, 8'd0, 8'd0}, 8'd0, 3'b101, 4);
    for (int r = 0; r < 6; r++) begin
      segment({8'($urandom_range(0, 30)), 8'($urandom_range(0, 30)),
               8'($urandom_range(0, 30)), 8'($urandom_range(0, 30))},
              8'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 6);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule